// File: doc/BRIEF.md
# Gated Random Byte Register Block

This block is a small register-mapped source of random bytes. Software reaches it through a single-cycle slave port: one address, a write strobe with write data, and a read strobe with read data that is valid in the same cycle. It has three byte registers: control, data and mode. The block holds at most one random byte. When that byte is present, a data-valid flag is shown in the control register. Reading the data register takes the byte away, and the block then fetches the next one.

Two separate settings must agree before the block produces anything. The enable bit in the control register must be set, and the mode register must hold the run code. Bytes come either from an external source port with a valid/ready handshake or from an internal LFSR that stands in for that source during test. An input pin chooses between the two.

A 4-bit prescaler paces refills. While the block waits for a byte, (prescaler+1) cycles must elapse before a byte may be taken.

The holding logic is a three-state machine:
- IDLE_OFF: inactive, nothing held.
- FILL_WAIT: active, waiting for the pacing interval and a byte.
- HOLD_FULL: a byte is held.

Its transitions are:
- WAKE: IDLE_OFF to FILL_WAIT when the block becomes active.
- LOAD: FILL_WAIT to HOLD_FULL when a byte is taken in.
- CONSUME: HOLD_FULL to FILL_WAIT on a valid data read.
- DROP: FILL_WAIT or HOLD_FULL to IDLE_OFF when the block becomes inactive.

Top module: `rng_byte_periph`

## Requirements
- R1: The control register is at offset 0x000, the data register at 0x004 and the mode register at 0x008. Reset clears all three to 0, so the block starts inactive. `bus_rdata` is 0 whenever `bus_rd` is low.
- R2: In the control register, bit 0 is the enable bit, bit 1 is data-valid, bits 5:2 are the prescaler, and bits 7:6 are plain storage. A write to the control register updates every bit except bit 1, which software can neither set nor clear.
- R3: The block is active only when the enable bit is 1 and the mode register holds exactly 0x02. Any other mode value leaves it inactive.
- R4: While the block is inactive, bit 1 of the control register reads 0.
- R5: While the block is active and holds no byte, a byte is loaded after the state machine has spent (prescaler+1) cycles in FILL_WAIT. The first byte after an enable write therefore shows valid prescaler+2 clock edges after the write edge. A refill after a consuming read shows valid prescaler+1 edges after the read edge.
- R6: A data-register read while the block is active and valid returns the held byte, clears valid and zeroes the stored byte. Any other data-register read returns 0.
- R7: With `use_lfsr` high, each loaded byte is the next state of an 8-bit LFSR. The LFSR is reset to 0x01 and steps only when it supplies a byte, with next = {cur[6:0], cur[7]^cur[5]^cur[4]^cur[3]}.
- R8: With `use_lfsr` low, `src_ready` is high in FILL_WAIT once the interval has elapsed. The byte is taken when `src_valid` and `src_ready` are both high. The LFSR does not step.
- R9: Writes to the data register are ignored. The mode register is fully writable and reads back as written.
- R10: `bus_err` is high in any cycle that writes the data register or reads or writes an unmapped offset. Unmapped reads return 0, and unmapped writes change nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_addr | input | 12 | Register byte offset |
| bus_wr | input | 1 | Write strobe |
| bus_wdata | input | 8 | Write data |
| bus_rd | input | 1 | Read strobe |
| bus_rdata | output | 8 | Read data, same cycle as bus_rd |
| bus_err | output | 1 | Access error pulse |
| use_lfsr | input | 1 | 1 selects the internal LFSR, 0 selects the external source |
| src_valid | input | 1 | External byte valid |
| src_data | input | 8 | External byte |
| src_ready | output | 1 | Block accepts an external byte |

## Verification
The bench sweeps all sixteen prescaler values and counts the edges from an enable write, and from a consuming read, to the appearance of valid. A pacer that is off by one, or that is not cleared between fills, shows up as a wrong latency. It also sweeps all 256 mode codes with the enable bit set. A gate that decodes only some of the mode bits would produce a byte for a wrong code.

Several checks look at the valid flag and at what is read back. Writes of bit 1 are made both while a byte is held and while the block waits; a flag that software can touch changes the control read-back. Reads of the data register made right after a consume, or made while inactive, must return 0, which exposes a byte that is left stale. Writes to the data register and accesses to unmapped offsets must leave every register as it was and must raise the error pulse.

// File: rtl/rngp_pkg.sv
package rngp_pkg;
    localparam int ADDR_W = 12;
    localparam int BYTE_W = 8;
    localparam int PSC_W  = 4;

    localparam logic [ADDR_W-1:0] OFS_CTRL = 12'h000;
    localparam logic [ADDR_W-1:0] OFS_DATA = 12'h004;
    localparam logic [ADDR_W-1:0] OFS_MODE = 12'h008;

    localparam logic [BYTE_W-1:0] MODE_RUN = 8'h02;

    localparam int CTRL_EN  = 0;
    localparam int CTRL_VLD = 1;
    localparam int CTRL_PSC = 2;

    typedef enum logic [1:0] {
        IDLE_OFF  = 2'd0,
        FILL_WAIT = 2'd1,
        HOLD_FULL = 2'd2
    } hold_st_e;
endpackage

// File: rtl/rngp_regs.sv
module rngp_regs
    import rngp_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ADDR_W-1:0] addr,
    input  logic              wr,
    input  logic              rd,
    input  logic [BYTE_W-1:0] wdata,
    output logic [BYTE_W-1:0] ctrl_q,
    output logic [BYTE_W-1:0] mode_q,
    output logic              sel_ctrl,
    output logic              sel_data,
    output logic              sel_mode,
    output logic              active,
    output logic              err
);
    localparam logic [BYTE_W-1:0] VLD_MASK = BYTE_W'(1) << CTRL_VLD;

    always_comb begin
        sel_ctrl = (addr == OFS_CTRL);
        sel_data = (addr == OFS_DATA);
        sel_mode = (addr == OFS_MODE);
    end

    // The valid bit is never stored here; the holder supplies it on read.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ctrl_q <= '0;
            mode_q <= '0;
        end else begin
            if (wr && sel_ctrl) ctrl_q <= wdata & ~VLD_MASK;
            if (wr && sel_mode) mode_q <= wdata;
        end
    end

    always_comb begin
        active = ctrl_q[CTRL_EN] && (mode_q == MODE_RUN);
        err    = (wr && sel_data) ||
                 ((wr || rd) && !(sel_ctrl || sel_data || sel_mode));
    end
endmodule

// File: rtl/rngp_pacer.sv
module rngp_pacer #(
    parameter int PW = 4
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          waiting,
    input  logic [PW-1:0] psc,
    output logic          elapsed
);
    logic [PW-1:0] cnt_q;

    always_ff @(posedge clk) begin
        if (!rst_n)           cnt_q <= '0;
        else if (!waiting)    cnt_q <= '0;
        else if (cnt_q < psc) cnt_q <= cnt_q + PW'(1);
    end

    assign elapsed = waiting && (cnt_q >= psc);
endmodule

// File: rtl/rngp_lfsr.sv
module rngp_lfsr #(
    parameter int            W    = 8,
    parameter logic [W-1:0]  SEED = 8'h01,
    parameter logic [W-1:0]  TAPS = 8'b1011_1000
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         step,
    output logic [W-1:0] next_val
);
    logic [W-1:0] q;

    assign next_val = {q[W-2:0], ^(q & TAPS)};

    always_ff @(posedge clk) begin
        if (!rst_n)    q <= SEED;
        else if (step) q <= next_val;
    end
endmodule

// File: rtl/rng_byte_periph.sv
module rng_byte_periph
    import rngp_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic              bus_wr,
    input  logic [BYTE_W-1:0] bus_wdata,
    input  logic              bus_rd,
    output logic [BYTE_W-1:0] bus_rdata,
    output logic              bus_err,
    input  logic              use_lfsr,
    input  logic              src_valid,
    input  logic [BYTE_W-1:0] src_data,
    output logic              src_ready
);
    logic [BYTE_W-1:0] ctrl_q, mode_q, data_q, lfsr_byte, load_byte;
    logic              sel_ctrl, sel_data, sel_mode, active;
    logic              waiting, elapsed, load, consume, valid_vis;
    hold_st_e          state_q, state_d;

    rngp_regs u_regs (
        .clk(clk), .rst_n(rst_n), .addr(bus_addr), .wr(bus_wr), .rd(bus_rd),
        .wdata(bus_wdata), .ctrl_q(ctrl_q), .mode_q(mode_q),
        .sel_ctrl(sel_ctrl), .sel_data(sel_data), .sel_mode(sel_mode),
        .active(active), .err(bus_err)
    );

    rngp_pacer #(.PW(PSC_W)) u_pacer (
        .clk(clk), .rst_n(rst_n), .waiting(waiting),
        .psc(ctrl_q[CTRL_PSC +: PSC_W]), .elapsed(elapsed)
    );

    rngp_lfsr #(.W(BYTE_W)) u_lfsr (
        .clk(clk), .rst_n(rst_n), .step(load && use_lfsr), .next_val(lfsr_byte)
    );

    // State register
    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= IDLE_OFF;
        else        state_q <= state_d;
    end

    // Next state: WAKE, LOAD, CONSUME, DROP
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            IDLE_OFF:  if (active) state_d = FILL_WAIT;
            FILL_WAIT: if (!active) state_d = IDLE_OFF;
                       else if (load) state_d = HOLD_FULL;
            HOLD_FULL: if (!active) state_d = IDLE_OFF;
                       else if (consume) state_d = FILL_WAIT;
            default:   state_d = IDLE_OFF;
        endcase
    end

    // State-derived outputs
    always_comb begin
        waiting   = (state_q == FILL_WAIT) && active;
        valid_vis = (state_q == HOLD_FULL) && active;
        consume   = bus_rd && sel_data && valid_vis;
        src_ready = elapsed && !use_lfsr;
        load      = elapsed && (use_lfsr || src_valid);
        load_byte = use_lfsr ? lfsr_byte : src_data;
    end

    always_ff @(posedge clk) begin
        if (!rst_n)                 data_q <= '0;
        else if (load)              data_q <= load_byte;
        else if (consume || !active) data_q <= '0;
    end

    always_comb begin
        bus_rdata = '0;
        if (bus_rd) begin
            if (sel_ctrl) begin
                bus_rdata           = ctrl_q;
                bus_rdata[CTRL_VLD] = valid_vis;
            end else if (sel_data) begin
                bus_rdata = valid_vis ? data_q : '0;
            end else if (sel_mode) begin
                bus_rdata = mode_q;
            end
        end
    end
endmodule

// File: rtl/rngp_chk.sv
module rngp_chk
    import rngp_pkg::*;
(
    input logic              clk,
    input logic              rst_n,
    input logic [ADDR_W-1:0] bus_addr,
    input logic              bus_wr,
    input logic              bus_rd,
    input logic [BYTE_W-1:0] bus_rdata,
    input logic              bus_err,
    input hold_st_e          state_q,
    input logic [BYTE_W-1:0] data_q,
    input logic [BYTE_W-1:0] mode_q,
    input logic              active
);
    logic mapped;
    assign mapped = (bus_addr == OFS_CTRL) || (bus_addr == OFS_DATA) ||
                    (bus_addr == OFS_MODE);

    AST_DATA_RD_EMPTY: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_rd && bus_addr == OFS_DATA && state_q != HOLD_FULL) |-> bus_rdata == '0); // R6

    AST_CONSUME_EMPTIES: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_rd && bus_addr == OFS_DATA && state_q == HOLD_FULL && active)
        |=> (state_q == FILL_WAIT && data_q == '0)); // R6

    AST_MODE_GATE: assert property (@(posedge clk) disable iff (!rst_n)
        (mode_q != MODE_RUN) |=> state_q == IDLE_OFF); // R3

    AST_FILL_FROM_WAIT: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == HOLD_FULL && $past(state_q) != HOLD_FULL)
        |-> $past(state_q) == FILL_WAIT); // R5

    AST_DATA_WR_IGNORED: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_wr && !bus_rd && bus_addr == OFS_DATA && state_q == HOLD_FULL && active)
        |=> $stable(data_q)); // R9

    AST_UNMAPPED_ERR: assert property (@(posedge clk) disable iff (!rst_n)
        ((bus_rd || bus_wr) && !mapped) |-> (bus_err && bus_rdata == '0)); // R10

    AST_DATA_WR_ERR: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_wr && bus_addr == OFS_DATA) |-> bus_err); // R10
endmodule

bind rng_byte_periph rngp_chk u_chk (
    .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_wr(bus_wr),
    .bus_rd(bus_rd), .bus_rdata(bus_rdata), .bus_err(bus_err),
    .state_q(state_q), .data_q(data_q), .mode_q(mode_q), .active(active)
);

// File: tb/tb_rng_byte_periph.sv
`timescale 1ns/1ps
module tb_rng_byte_periph;
    import rngp_pkg::*;

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic [ADDR_W-1:0] bus_addr = '0;
    logic              bus_wr = 1'b0;
    logic [BYTE_W-1:0] bus_wdata = '0;
    logic              bus_rd = 1'b0;
    logic [BYTE_W-1:0] bus_rdata;
    logic              bus_err;
    logic              use_lfsr = 1'b1;
    logic              src_valid = 1'b0;
    logic [BYTE_W-1:0] src_data = '0;
    logic              src_ready;

    int   n_chk = 0;
    int   n_fail = 0;
    logic [7:0] lf = 8'h01;

    always #2 clk = ~clk;

    rng_byte_periph dut (
        .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_wr(bus_wr),
        .bus_wdata(bus_wdata), .bus_rd(bus_rd), .bus_rdata(bus_rdata),
        .bus_err(bus_err), .use_lfsr(use_lfsr), .src_valid(src_valid),
        .src_data(src_data), .src_ready(src_ready)
    );

    function automatic logic [7:0] lfsr_step(input logic [7:0] x);
        return {x[6:0], x[7] ^ x[5] ^ x[4] ^ x[3]};
    endfunction

    task automatic chk(input string req, input int act, input int exp);
        n_chk++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, exp);
        end
    endtask

    task automatic bwr(input logic [11:0] a, input logic [7:0] d, output bit e);
        @(negedge clk);
        bus_addr = a; bus_wdata = d; bus_wr = 1'b1;
        #1 e = bus_err;
        @(negedge clk);
        bus_wr = 1'b0; bus_addr = '0;
    endtask

    task automatic brd(input logic [11:0] a, output logic [7:0] d, output bit e);
        @(negedge clk);
        bus_addr = a; bus_rd = 1'b1;
        #1 d = bus_rdata; e = bus_err;
        @(negedge clk);
        bus_rd = 1'b0; bus_addr = '0;
    endtask

    // Called at the negedge after an access edge; counts edges to valid.
    task automatic wait_valid(output int n);
        bus_addr = OFS_CTRL; bus_rd = 1'b1; n = 0;
        #1;
        while (!bus_rdata[1] && n < 64) begin
            @(negedge clk); #1; n++;
        end
        bus_rd = 1'b0; bus_addr = '0;
    endtask

    initial begin
        #(4 * 150000);
        n_fail++;
        $display("FAIL watchdog actual=hung expected=done");
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

    initial begin
        logic [7:0] d;
        bit e;
        int n;

        repeat (3) @(negedge clk);
        rst_n = 1'b1;

        // R1 reset state and idle read bus
        #1 chk("R1 idle rdata", bus_rdata, 0);
        brd(OFS_CTRL, d, e); chk("R1 ctrl reset", d, 0);
        brd(OFS_DATA, d, e); chk("R1 data reset", d, 0);
        brd(OFS_MODE, d, e); chk("R1 mode reset", d, 0);
        chk("R10 no err mapped read", e, 0);

        // R5 R6 R7 prescaler sweep with internal source
        bwr(OFS_MODE, 8'h02, e);
        for (int p = 0; p < 16; p++) begin
            bwr(OFS_CTRL, {2'b00, 4'(p), 2'b01}, e);
            wait_valid(n); chk($sformatf("R5 first fill psc=%0d", p), n, p + 2);
            brd(OFS_CTRL, d, e); chk("R2 ctrl readback full", d, {2'b00, 4'(p), 2'b11});
            lf = lfsr_step(lf);
            brd(OFS_DATA, d, e); chk("R7 lfsr byte 1", d, lf);
            wait_valid(n); chk($sformatf("R5 refill psc=%0d", p), n, p + 1);
            lf = lfsr_step(lf);
            brd(OFS_DATA, d, e); chk("R6 R7 lfsr byte 2", d, lf);
            if (p >= 1) begin
                brd(OFS_DATA, d, e); chk("R6 read after consume", d, 0);
            end
            wait_valid(n);
            lf = lfsr_step(lf);
            brd(OFS_DATA, d, e); chk("R7 lfsr byte 3", d, lf);
            wait_valid(n);
            lf = lfsr_step(lf);
            bwr(OFS_CTRL, 8'h00, e);
            brd(OFS_CTRL, d, e); chk("R4 valid cleared on disable", d, 0);
            brd(OFS_DATA, d, e); chk("R6 data read inactive", d, 0);
        end

        // R3 mode sweep
        for (int m = 0; m < 256; m++) begin
            bwr(OFS_CTRL, 8'h00, e);
            bwr(OFS_MODE, 8'(m), e);
            bwr(OFS_CTRL, 8'h01, e);
            brd(OFS_MODE, d, e); chk("R9 mode readback", d, m);
            brd(OFS_CTRL, d, e);
            chk($sformatf("R3 gate mode=%0h", m), d, (m == 2) ? 8'h03 : 8'h01);
            if (m == 2) lf = lfsr_step(lf);
        end
        bwr(OFS_CTRL, 8'h00, e);

        // R2 valid read-only, R9 data write ignored
        bwr(OFS_MODE, 8'h02, e);
        bwr(OFS_CTRL, 8'h3D, e);
        wait_valid(n); chk("R5 fill psc=15", n, 17);
        lf = lfsr_step(lf);
        bwr(OFS_CTRL, 8'h3D, e);
        brd(OFS_CTRL, d, e); chk("R2 sw cannot clear valid", d, 8'h3F);
        bwr(OFS_DATA, 8'h00, e); chk("R10 err on data write", e, 1);
        brd(OFS_DATA, d, e); chk("R9 data write ignored", d, lf);
        bwr(OFS_CTRL, 8'h3F, e);
        brd(OFS_CTRL, d, e); chk("R2 sw cannot set valid", d, 8'h3D);
        bwr(OFS_CTRL, 8'h00, e);

        // R2 R4 readback while inactive, R10 unmapped
        bwr(OFS_MODE, 8'h5A, e);
        bwr(OFS_CTRL, 8'hFF, e);
        brd(OFS_CTRL, d, e); chk("R2 R4 ctrl readback inactive", d, 8'hFD);
        brd(12'h00C, d, e); chk("R10 unmapped read data", d, 0); chk("R10 unmapped read err", e, 1);
        brd(12'h001, d, e); chk("R10 unaligned read data", d, 0); chk("R10 unaligned read err", e, 1);
        bwr(12'h010, 8'h00, e); chk("R10 unmapped write err", e, 1);
        bwr(12'h009, 8'h00, e);
        brd(OFS_CTRL, d, e); chk("R10 ctrl untouched", d, 8'hFD);
        brd(OFS_MODE, d, e); chk("R10 mode untouched", d, 8'h5A);

        // R8 external source
        bwr(OFS_CTRL, 8'h00, e);
        use_lfsr = 1'b0;
        bwr(OFS_MODE, 8'h02, e);
        bwr(OFS_CTRL, 8'h01, e);
        repeat (5) @(negedge clk);
        #1 chk("R8 ready while waiting", src_ready, 1);
        brd(OFS_CTRL, d, e); chk("R8 no byte without valid", d, 8'h01);
        @(negedge clk);
        src_data = 8'hA5; src_valid = 1'b1;
        @(negedge clk);
        src_valid = 1'b0;
        #1 chk("R8 ready low when full", src_ready, 0);
        brd(OFS_DATA, d, e); chk("R8 external byte", d, 8'hA5);
        use_lfsr = 1'b1;
        wait_valid(n);
        lf = lfsr_step(lf);
        brd(OFS_DATA, d, e); chk("R7 lfsr not stepped by external", d, lf);

        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end
endmodule